// File: doc/BRIEF.md
# Modified-Line Writeback Merge Controller

This block is the response side of a memory controller for a shared bus where caching agents snoop every memory transaction. It takes one request at a time, along with the snoop outcome for that request. When no cache holds the line dirty, reads go to memory and writes go to memory. When one snooper reports a dirty (modified) copy, the controller turns the transaction into an implicit writeback. It answers the requester with a writeback-type response, collects the dirty line from the snooper, and commits the correct line image to memory.

A write that covers only part of a line and collides with a dirty copy needs extra handling. The controller first takes the requester's bytes, then takes the snooper's full line, and builds the final line by picking, byte by byte, the requester's byte wherever its enable is set and the snooper's byte everywhere else. For a full-line write the controller also takes the requester's data first, and only then tells the snooper it may drive its line. For a full-line read-and-invalidate with a dirty hit, a configuration bit can drop the memory write, because the requester is about to modify the line anyway.

Top module: `iwb_merge_ctrl`

## Requirements
- R1: Request kind encoding on `req_kind` is 2'b00 read, 2'b01 write, 2'b10 read-and-invalidate; 2'b11 behaves as a read. A request is accepted on a rising edge where `req_valid` is high and `busy` is low. `busy` is high from the next cycle until the transaction ends. Requests presented while `busy` is high are ignored. After reset `busy`, `rsp_valid`, `trdy_snoop`, `wdat_ready` and `mem_wr_valid` are low.
- R2: In the cycle after acceptance, `rsp_valid` is high for exactly one cycle. `rsp_iwb` is 1 in that cycle if and only if `snoop_hitm` was 1 at acceptance.
- R3: A read or read-and-invalidate without a dirty hit raises `mem_rd_valid` in the response cycle with `mem_rd_addr` equal to the request address. It makes no memory write, and `busy` is low in the following cycle.
- R4: A write without a dirty hit raises `wdat_ready` after the response cycle and holds it until `wdat_valid` is seen. Memory then receives the requester line with the request byte enables unchanged.
- R5: A read with a dirty hit raises `trdy_snoop` after the response cycle and holds it until `wb_valid` is seen. Memory then receives the snooper line with every byte enable set.
- R6: A partial write with a dirty hit takes the requester data first and the snooper line second. Memory byte b gets the requester byte when `req_be[b]` is 1 and the snooper byte otherwise, with every byte enable set.
- R7: For any write, `trdy_snoop` stays low until the requester data has been accepted. A full-line write with a dirty hit commits the requester line.
- R8: A read-and-invalidate with a dirty hit accepts the snooper line. When `cfg_skip_rdinv_wb` was 1 at acceptance, no memory write follows and `busy` is low in the cycle after the snooper handshake. When it was 0, the line is written as in R5.
- R9: `mem_wr_valid` holds with stable address, data and enables until `mem_wr_ready` is seen. `busy` is low in the cycle after that handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | Transaction kind (R1 encoding) |
| req_addr | input | ADDR_W | Line address |
| req_be | input | LINE_BYTES | Per-byte write enables for writes |
| snoop_hitm | input | 1 | Snoop found a dirty copy |
| cfg_skip_rdinv_wb | input | 1 | Drop memory write for dirty read-and-invalidate |
| busy | output | 1 | Transaction in progress |
| rsp_valid | output | 1 | Response pulse to requester |
| rsp_iwb | output | 1 | Response is implicit writeback type |
| mem_rd_valid | output | 1 | Memory read issue pulse |
| mem_rd_addr | output | ADDR_W | Memory read address |
| wdat_valid | input | 1 | Requester write data present |
| wdat_ready | output | 1 | Controller ready for requester data |
| wdat_data | input | 8*LINE_BYTES | Requester line data |
| wb_valid | input | 1 | Snooper writeback data present |
| wb_data | input | 8*LINE_BYTES | Snooper dirty line |
| trdy_snoop | output | 1 | Target ready toward snooper |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_ready | input | 1 | Memory write accepted |
| mem_wr_addr | output | ADDR_W | Memory write address |
| mem_wr_data | output | 8*LINE_BYTES | Memory write line |
| mem_wr_be | output | LINE_BYTES | Memory write byte enables |

## Verification
The bench sweeps every byte-enable pattern of a four-byte line through writes with and without a dirty hit. A merge that swapped its select, or that wrote partial enables after a collision, would corrupt or drop snooper bytes in at least one pattern. Every write checks that the snooper ready stays low while requester data is pending, so a design that opened the writeback window early is caught. Both settings of the skip bit are run on dirty read-and-invalidate, which catches a lost or spurious memory write. Memory back-pressure of varying length, and a request presented while busy, show whether the write is held stable and whether extra transactions get in.

// File: rtl/iwb_pkg.sv
package iwb_pkg;
  typedef enum logic [1:0] {
    KIND_READ  = 2'b00,
    KIND_WRITE = 2'b01,
    KIND_RDINV = 2'b10,
    KIND_RSVD  = 2'b11
  } iwb_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RESP = 3'd1,
    ST_WDAT = 3'd2,
    ST_WB   = 3'd3,
    ST_MEMW = 3'd4
  } iwb_state_e;
endpackage

// File: rtl/iwb_byte_merge.sv
module iwb_byte_merge #(
  parameter int LINE_BYTES = 64
) (
  input  logic [LINE_BYTES-1:0]   sel_req,
  input  logic [8*LINE_BYTES-1:0] req_line,
  input  logic [8*LINE_BYTES-1:0] snp_line,
  output logic [8*LINE_BYTES-1:0] out_line
);
  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
    assign out_line[8*b +: 8] = sel_req[b] ? req_line[8*b +: 8] : snp_line[8*b +: 8];
  end
endmodule

// File: rtl/iwb_seq_fsm.sv
module iwb_seq_fsm
  import iwb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       is_write_q,
  input  logic       is_rdinv_q,
  input  logic       hitm_q,
  input  logic       skip_q,
  input  logic       wdat_fire,
  input  logic       wb_fire,
  input  logic       memw_fire,
  output iwb_state_e state_q
);
  iwb_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_RESP;
      ST_RESP: begin
        if (is_write_q)  state_d = ST_WDAT;
        else if (hitm_q) state_d = ST_WB;
        else             state_d = ST_IDLE;
      end
      ST_WDAT: if (wdat_fire) state_d = hitm_q ? ST_WB : ST_MEMW;
      ST_WB:   if (wb_fire)   state_d = (is_rdinv_q && skip_q) ? ST_IDLE : ST_MEMW;
      ST_MEMW: if (memw_fire) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/iwb_merge_ctrl.sv
module iwb_merge_ctrl
  import iwb_pkg::*;
#(
  parameter int LINE_BYTES = 64,
  parameter int ADDR_W     = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [1:0]              req_kind,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [LINE_BYTES-1:0]   req_be,
  input  logic                    snoop_hitm,
  input  logic                    cfg_skip_rdinv_wb,
  output logic                    busy,
  output logic                    rsp_valid,
  output logic                    rsp_iwb,
  output logic                    mem_rd_valid,
  output logic [ADDR_W-1:0]       mem_rd_addr,
  input  logic                    wdat_valid,
  output logic                    wdat_ready,
  input  logic [8*LINE_BYTES-1:0] wdat_data,
  input  logic                    wb_valid,
  input  logic [8*LINE_BYTES-1:0] wb_data,
  output logic                    trdy_snoop,
  output logic                    mem_wr_valid,
  input  logic                    mem_wr_ready,
  output logic [ADDR_W-1:0]       mem_wr_addr,
  output logic [8*LINE_BYTES-1:0] mem_wr_data,
  output logic [LINE_BYTES-1:0]   mem_wr_be
);
  localparam int LINE_W = 8 * LINE_BYTES;

  iwb_state_e            state_q;
  logic                  accept, wdat_fire, wb_fire, memw_fire;
  logic                  is_write_q, is_rdinv_q, hitm_q, skip_q;
  logic                  is_write_d, is_rdinv_d, hitm_d, skip_d;
  logic [ADDR_W-1:0]     addr_q, addr_d;
  logic [LINE_BYTES-1:0] be_q, be_d;
  logic [LINE_W-1:0]     line_q, line_d, merged;
  logic                  line_en;

  assign accept    = req_valid && (state_q == ST_IDLE);
  assign wdat_fire = wdat_valid && wdat_ready;
  assign wb_fire   = wb_valid && trdy_snoop;
  assign memw_fire = mem_wr_valid && mem_wr_ready;

  iwb_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .is_write_q (is_write_q),
    .is_rdinv_q (is_rdinv_q),
    .hitm_q     (hitm_q),
    .skip_q     (skip_q),
    .wdat_fire  (wdat_fire),
    .wb_fire    (wb_fire),
    .memw_fire  (memw_fire),
    .state_q    (state_q)
  );

  iwb_byte_merge #(.LINE_BYTES(LINE_BYTES)) u_merge (
    .sel_req  (be_q),
    .req_line (line_q),
    .snp_line (wb_data),
    .out_line (merged)
  );

  // capture of the request attributes
  always_comb begin
    is_write_d = is_write_q;
    is_rdinv_d = is_rdinv_q;
    hitm_d     = hitm_q;
    skip_d     = skip_q;
    addr_d     = addr_q;
    be_d       = be_q;
    if (accept) begin
      is_write_d = (req_kind == KIND_WRITE);
      is_rdinv_d = (req_kind == KIND_RDINV);
      hitm_d     = snoop_hitm;
      skip_d     = cfg_skip_rdinv_wb;
      addr_d     = req_addr;
      be_d       = (req_kind == KIND_WRITE) ? req_be : '0;
    end
  end

  // line buffer: requester data first, then overlay onto snooper line
  always_comb begin
    line_en = wdat_fire || wb_fire;
    line_d  = wb_fire ? merged : wdat_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_write_q <= 1'b0;
      is_rdinv_q <= 1'b0;
      hitm_q     <= 1'b0;
      skip_q     <= 1'b0;
      addr_q     <= '0;
      be_q       <= '0;
    end else if (accept) begin
      is_write_q <= is_write_d;
      is_rdinv_q <= is_rdinv_d;
      hitm_q     <= hitm_d;
      skip_q     <= skip_d;
      addr_q     <= addr_d;
      be_q       <= be_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       line_q <= '0;
    else if (line_en) line_q <= line_d;
  end

  assign busy         = (state_q != ST_IDLE);
  assign rsp_valid    = (state_q == ST_RESP);
  assign rsp_iwb      = rsp_valid && hitm_q;
  assign mem_rd_valid = rsp_valid && !is_write_q && !hitm_q;
  assign mem_rd_addr  = addr_q;
  assign wdat_ready   = (state_q == ST_WDAT);
  assign trdy_snoop   = (state_q == ST_WB);
  assign mem_wr_valid = (state_q == ST_MEMW);
  assign mem_wr_addr  = addr_q;
  assign mem_wr_data  = line_q;
  assign mem_wr_be    = hitm_q ? {LINE_BYTES{1'b1}} : be_q;
endmodule

// File: rtl/iwb_merge_chk.sv
module iwb_merge_chk #(
  parameter int LINE_BYTES = 64,
  parameter int ADDR_W     = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic [1:0]              req_kind,
  input logic                    snoop_hitm,
  input logic                    busy,
  input logic                    rsp_valid,
  input logic                    rsp_iwb,
  input logic                    wdat_valid,
  input logic                    wdat_ready,
  input logic                    trdy_snoop,
  input logic                    mem_wr_valid,
  input logic                    mem_wr_ready,
  input logic [ADDR_W-1:0]       mem_wr_addr,
  input logic [8*LINE_BYTES-1:0] mem_wr_data,
  input logic [LINE_BYTES-1:0]   mem_wr_be
);
  logic acc, wr_q, hit_q, saw_wdat;
  assign acc = req_valid && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q     <= 1'b0;
      hit_q    <= 1'b0;
      saw_wdat <= 1'b0;
    end else if (acc) begin
      wr_q     <= (req_kind == 2'b01);
      hit_q    <= snoop_hitm;
      saw_wdat <= 1'b0;
    end else if (wdat_valid && wdat_ready) begin
      saw_wdat <= 1'b1;
    end
  end

  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> busy);

  assert_rsp_kind_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (rsp_valid && (rsp_iwb == $past(snoop_hitm))));

  assert_no_read_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> (hit_q || wr_q));

  assert_full_be_on_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && hit_q) |-> (&mem_wr_be));

  assert_wdat_before_trdy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trdy_snoop && wr_q) |-> saw_wdat);

  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=>
      (mem_wr_valid && $stable(mem_wr_data) && $stable(mem_wr_addr) && $stable(mem_wr_be)));
endmodule

bind iwb_merge_ctrl iwb_merge_chk #(.LINE_BYTES(LINE_BYTES), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_kind     (req_kind),
  .snoop_hitm   (snoop_hitm),
  .busy         (busy),
  .rsp_valid    (rsp_valid),
  .rsp_iwb      (rsp_iwb),
  .wdat_valid   (wdat_valid),
  .wdat_ready   (wdat_ready),
  .trdy_snoop   (trdy_snoop),
  .mem_wr_valid (mem_wr_valid),
  .mem_wr_ready (mem_wr_ready),
  .mem_wr_addr  (mem_wr_addr),
  .mem_wr_data  (mem_wr_data),
  .mem_wr_be    (mem_wr_be)
);

// File: tb/tb_iwb_merge_ctrl.sv
module tb_iwb_merge_ctrl;
  localparam int LB = 4;
  localparam int AW = 16;
  localparam int W  = 8 * LB;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic [1:0]    req_kind;
  logic [AW-1:0] req_addr;
  logic [LB-1:0] req_be;
  logic          snoop_hitm;
  logic          cfg_skip;
  logic          busy, rsp_valid, rsp_iwb, mem_rd_valid;
  logic [AW-1:0] mem_rd_addr;
  logic          wdat_valid, wdat_ready;
  logic [W-1:0]  wdat_data;
  logic          wb_valid;
  logic [W-1:0]  wb_data;
  logic          trdy_snoop, mem_wr_valid, mem_wr_ready;
  logic [AW-1:0] mem_wr_addr;
  logic [W-1:0]  mem_wr_data;
  logic [LB-1:0] mem_wr_be;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  iwb_merge_ctrl #(.LINE_BYTES(LB), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_be(req_be), .snoop_hitm(snoop_hitm),
    .cfg_skip_rdinv_wb(cfg_skip), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_iwb(rsp_iwb), .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .wdat_valid(wdat_valid), .wdat_ready(wdat_ready), .wdat_data(wdat_data),
    .wb_valid(wb_valid), .wb_data(wb_data), .trdy_snoop(trdy_snoop),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] merge_exp(input logic [LB-1:0] be,
                                              input logic [W-1:0] r, input logic [W-1:0] s);
    logic [W-1:0] m;
    for (int b = 0; b < LB; b++) m[8*b +: 8] = be[b] ? r[8*b +: 8] : s[8*b +: 8];
    return m;
  endfunction

  task automatic txn(input logic [1:0] k, input bit h, input logic [LB-1:0] be,
                     input bit skip, input logic [AW-1:0] a,
                     input logic [W-1:0] rl, input logic [W-1:0] wl, input int stall);
    bit is_wr = (k == 2'b01);
    bit writes_mem = is_wr || (h && !(k == 2'b10 && skip));
    logic [W-1:0]  exp_d;
    logic [LB-1:0] exp_be;
    if (!h)         begin exp_d = rl; exp_be = be; end
    else if (is_wr) begin exp_d = merge_exp(be, rl, wl); exp_be = '1; end
    else            begin exp_d = wl; exp_be = '1; end

    @(negedge clk);
    chk("R1 idle before request", busy, 0);
    req_valid = 1; req_kind = k; req_addr = a; req_be = be;
    snoop_hitm = h; cfg_skip = skip;
    @(negedge clk);
    chk("R1 busy after accept", busy, 1);
    chk("R2 rsp_valid", rsp_valid, 1);
    chk("R2 rsp_iwb", rsp_iwb, h);
    chk("R3 mem_rd_valid", mem_rd_valid, (!is_wr && !h));
    if (!is_wr && !h) chk("R3 mem_rd_addr", mem_rd_addr, a);
    // a stray request while busy must be ignored (R1)
    req_kind = 2'b01; req_addr = a ^ 16'hFFFF; snoop_hitm = ~h;
    @(negedge clk);
    req_valid = 0;
    chk("R2 single response pulse", rsp_valid, 0);
    if (!is_wr && !h) begin
      chk("R3 busy clears", busy, 0);
      chk("R3 no mem write", mem_wr_valid, 0);
      return;
    end
    if (is_wr) begin
      chk("R4 wdat_ready", wdat_ready, 1);
      chk("R7 no trdy before data", trdy_snoop, 0);
      @(negedge clk);
      chk("R4 wdat_ready held", wdat_ready, 1);
      chk("R7 no trdy while waiting", trdy_snoop, 0);
      wdat_valid = 1; wdat_data = rl;
      @(negedge clk);
      wdat_valid = 0; wdat_data = '0;
    end
    if (h) begin
      chk("R5 trdy_snoop", trdy_snoop, 1);
      chk("R6 wdat_ready low in writeback", wdat_ready, 0);
      wb_valid = 1; wb_data = wl;
      @(negedge clk);
      wb_valid = 0; wb_data = '0;
    end
    if (writes_mem) begin
      for (int s = 0; s <= stall; s++) begin
        chk("R9 mem_wr_valid", mem_wr_valid, 1);
        chk(h ? (is_wr ? "R6 merged data" : "R5 writeback data") : "R4 write data",
            mem_wr_data, exp_d);
        chk(h ? "R6 full enables" : "R4 request enables", mem_wr_be, exp_be);
        chk("R9 mem_wr_addr", mem_wr_addr, a);
        if (s == stall) mem_wr_ready = 1;
        @(negedge clk);
      end
      mem_wr_ready = 0;
      chk("R9 busy after handshake", busy, 0);
      chk("R1 no stray response", rsp_valid, 0);
    end else begin
      chk("R8 skip leaves idle", busy, 0);
      chk("R8 no mem write", mem_wr_valid, 0);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; req_valid = 0; req_kind = 0; req_addr = 0; req_be = 0;
    snoop_hitm = 0; cfg_skip = 0; wdat_valid = 0; wdat_data = 0;
    wb_valid = 0; wb_data = 0; mem_wr_ready = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset rsp_valid", rsp_valid, 0);
    chk("R1 reset trdy", trdy_snoop, 0);
    chk("R1 reset wdat_ready", wdat_ready, 0);
    chk("R1 reset mem_wr_valid", mem_wr_valid, 0);
    rst_n = 1;

    // R6 / R7: every enable pattern, dirty hit (15 is the full line)
    for (int i = 0; i < 16; i++)
      txn(2'b01, 1, i[LB-1:0], 0, AW'(16'h1000 + i*64),
          32'hA0A1A2A3 ^ (i * 32'h01010101), 32'h50515253 + i, i % 3);
    // R4: every enable pattern, no hit
    for (int i = 0; i < 16; i++)
      txn(2'b01, 0, i[LB-1:0], 0, AW'(16'h2000 + i*64),
          32'hC0C1C2C3 + i, 32'h0, (i + 1) % 3);
    // R5 / R3: reads
    txn(2'b00, 1, '0, 0, 16'h3000, 32'h0, 32'h11223344, 2);
    txn(2'b00, 0, '0, 0, 16'h3040, 32'h0, 32'h0, 0);
    txn(2'b11, 1, '0, 1, 16'h3080, 32'h0, 32'h55667788, 0);
    txn(2'b11, 0, '0, 0, 16'h30C0, 32'h0, 32'h0, 0);
    // R8 / R3: read-and-invalidate
    txn(2'b10, 0, '0, 0, 16'h4000, 32'h0, 32'h0, 0);
    txn(2'b10, 1, '0, 0, 16'h4040, 32'h0, 32'h99AABBCC, 1);
    txn(2'b10, 1, '0, 1, 16'h4080, 32'h0, 32'hDDEEFF01, 0);
    txn(2'b10, 0, '0, 1, 16'h40C0, 32'h0, 32'h0, 0);
    // back-to-back after skip, then a long memory stall (R9)
    txn(2'b01, 1, 4'b0110, 0, 16'h5000, 32'h12345678, 32'h9ABCDEF0, 5);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule